// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM refreshed without ever presenting a row address. After reset it keeps the RAS and CAS strobes idle for a power-up pause, then runs a fixed burst of wake-up refresh cycles on its own. Only then does it declare the memory ready for normal traffic. From that point a free-running interval timer adds one owed refresh per period to a small saturating count.

While anything is owed and no refresh cycle is in flight, the block raises a request toward the access controller. When the count is full it also raises an urgent flag, which tells the controller to close any open page at once. On a cycle where request and grant are both high, the block takes the strobes. It lowers CAS first, then RAS, holds RAS low for the minimum active width, and finishes with a precharge gap. Refreshes that were put off are caught up later from the count.

All timing is given in clock cycles through parameters, so one netlist covers any clock rate and either refresh density. The reset input is asynchronous and active low, and the block releases it synchronously inside.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is active, `ready`, `req` and `urgent` are 0, `ras_n` and `cas_n` are 1, and `strobe_own` is 1.
- R2: For at least `PAUSE_CYC` clock cycles after reset is released, `ras_n` and `cas_n` stay at 1 and `ready` stays at 0.
- R3: After the pause, exactly `WAKE_CYC` refresh cycles (falling edges of `ras_n`) occur with `grant` held at 0, and then `ready` rises. Once high, `ready` stays high until the next reset.
- R4: Every refresh cycle is CAS-before-RAS. `cas_n` falls only after `ras_n` has been high for at least `T_RPC` cycles. `cas_n` is low for exactly `T_CSR` cycles before `ras_n` falls, and it is still low in the cycle where `ras_n` falls.
- R5: `ras_n` stays low for exactly `T_RAS` cycles. `cas_n` stays low for exactly `T_CHR` cycles after `ras_n` falls, so its total low time is `T_CSR + T_CHR`.
- R6: Between two refresh cycles, `ras_n` is high for at least `T_RP + T_RPC + T_CSR` cycles.
- R7: Once `ready` is high, one refresh is added to the owed count every `INTERVAL_CYC` cycles. `req` is 1 exactly when the owed count is non-zero and no refresh cycle is in flight. The first `req` comes exactly `INTERVAL_CYC` cycles after `ready` rises.
- R8: In the ready phase, a refresh cycle starts only on a clock edge where both `req` and `grant` are 1. With `grant` at 0 the strobes stay high, and the owed count keeps growing.
- R9: The owed count saturates at `MAX_OWED`. `urgent` is 1 exactly when the count equals `MAX_OWED`, which first happens `MAX_OWED * INTERVAL_CYC` cycles after `ready` rises when no grant is given.
- R10: If an interval tick and a refresh start land on the same clock edge, the owed count is unchanged. This holds even when the count is full.
- R11: `strobe_own` is 1 whenever `ready` is 0 and during every refresh cycle. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Access controller hands the strobes to the refresh engine |
| req | output | 1 | At least one refresh owed and the engine is idle |
| urgent | output | 1 | Owed count is full; the open page should be closed now |
| ready | output | 1 | Power-up pause and wake-up refreshes are complete |
| strobe_own | output | 1 | The refresh engine is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low (both byte lanes) |

## Verification
The interval tick, which adds to the owed count, and a granted refresh start, which takes one away, can fall on the same clock edge. The worst case is when the count is full. The bench lets the count saturate with `grant` low. It then tracks the tick phase itself and raises `grant` for one cycle only, on the cycle just before a tick edge. A lost or extra update would show at the ports: after that edge a refresh cycle must be under way and `urgent` must still be high. In addition, a cycle-by-cycle model of the owed count is compared with `req` and `urgent` for the whole run, including the catch-up burst that follows.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Life phase of the scheduler after reset
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // Steps of one CAS-before-RAS cycle
  typedef enum logic [2:0] {
    CY_IDLE = 3'd0,
    CY_RPC  = 3'd1,
    CY_CSR  = 3'd2,
    CY_RAS  = 3'd3,
    CY_RP   = 3'd4
  } cyc_t;

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int PAUSE_CYC    = 20000,
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic pause_done,
  output logic tick
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] IVL_LAST   = IW'(INTERVAL_CYC - 1);

  logic [PW-1:0] pause_cnt, pause_cnt_n;
  logic          pause_q, pause_q_n;
  logic          pause_en;
  logic [IW-1:0] ivl_cnt, ivl_cnt_n;

  // power-up pause: counts once, then parks
  always_comb begin
    pause_en    = !pause_q;
    pause_cnt_n = pause_cnt + PW'(1);
    pause_q_n   = (pause_cnt == PAUSE_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_cnt <= '0;
      pause_q   <= 1'b0;
    end else if (pause_en) begin
      pause_cnt <= pause_cnt_n;
      pause_q   <= pause_q_n;
    end
  end

  // refresh interval: runs only in the ready phase
  always_comb begin
    tick = run_en && (ivl_cnt == IVL_LAST);
    if (!run_en || tick) ivl_cnt_n = '0;
    else                 ivl_cnt_n = ivl_cnt + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ivl_cnt <= '0;
    else        ivl_cnt <= ivl_cnt_n;
  end

  assign pause_done = pause_q;

endmodule

// File: rtl/rfsh_owed.sv
module rfsh_owed #(
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic empty,
  output logic full
);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] OWED_TOP = OW'(MAX_OWED);

  logic [OW-1:0] owed, owed_n;
  logic          owed_en;

  always_comb begin
    owed_n  = owed;
    owed_en = 1'b0;
    if (inc && !dec && (owed != OWED_TOP)) begin
      owed_n  = owed + OW'(1);
      owed_en = 1'b1;
    end else if (dec && !inc && (owed != '0)) begin
      owed_n  = owed - OW'(1);
      owed_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owed <= '0;
    else if (owed_en) owed <= owed_n;
  end

  assign empty = (owed == '0);
  assign full  = (owed == OWED_TOP);

  // a full count absorbs further ticks
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && inc && !dec) |=> full);

  // coinciding tick and start cancel out
  assert_net_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(owed));

  // a start is only ever taken against an owed refresh
  assert_dec_owed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !empty);

endmodule

// File: rtl/rfsh_cycle.sv
module rfsh_cycle
  import rfsh_pkg::*;
#(
  parameter int T_RPC = 1,
  parameter int T_CSR = 1,
  parameter int T_RAS = 7,
  parameter int T_CHR = 2,
  parameter int T_RP  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic ras_n,
  output logic cas_n
);
  localparam int M1   = (T_RPC > T_CSR) ? T_RPC : T_CSR;
  localparam int M2   = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int MAXD = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] L_RPC = CW'(T_RPC - 1);
  localparam logic [CW-1:0] L_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] CHR_W = CW'(T_CHR);

  cyc_t          state, state_n;
  logic [CW-1:0] cnt, cnt_n, last_val;
  logic          cnt_en, last;

  always_comb begin
    case (state)
      CY_RPC:  last_val = L_RPC;
      CY_CSR:  last_val = L_CSR;
      CY_RAS:  last_val = L_RAS;
      CY_RP:   last_val = L_RP;
      default: last_val = '0;
    endcase
    last = (cnt == last_val);
  end

  always_comb begin
    state_n = state;
    cnt_n   = cnt + CW'(1);
    cnt_en  = 1'b0;
    case (state)
      CY_IDLE: if (start) begin
        state_n = CY_RPC;
        cnt_n   = '0;
        cnt_en  = 1'b1;
      end
      CY_RPC: begin
        cnt_en = 1'b1;
        if (last) begin state_n = CY_CSR; cnt_n = '0; end
      end
      CY_CSR: begin
        cnt_en = 1'b1;
        if (last) begin state_n = CY_RAS; cnt_n = '0; end
      end
      CY_RAS: begin
        cnt_en = 1'b1;
        if (last) begin state_n = CY_RP; cnt_n = '0; end
      end
      CY_RP: begin
        cnt_en = 1'b1;
        if (last) begin state_n = CY_IDLE; cnt_n = '0; end
      end
      default: begin
        state_n = CY_IDLE;
        cnt_n   = '0;
        cnt_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CY_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      if (cnt_en) cnt <= cnt_n;
    end
  end

  assign busy  = (state != CY_IDLE);
  assign ras_n = (state != CY_RAS);
  assign cas_n = !((state == CY_CSR) || ((state == CY_RAS) && (cnt < CHR_W)));

  // RAS may only fall onto an already low CAS
  assert_cas_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // CAS never rises while RAS is still high inside a cycle
  assert_cas_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_n) && busy) |-> !ras_n);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int WAKE_CYC     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_OWED     = 8,
  parameter int T_RPC        = 1,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 7,
  parameter int T_CHR        = 2,
  parameter int T_RP         = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic req,
  output logic urgent,
  output logic ready,
  output logic strobe_own,
  output logic ras_n,
  output logic cas_n
);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic          rst_meta_n, rst_sync_n;
  phase_t        phase, phase_n;
  logic [WW-1:0] wake_left, wake_left_n;
  logic          wake_en;
  logic          pause_done, tick, busy, empty, full;
  logic          start_wake, start_run, start_any;

  // reset: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rfsh_timer #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_en    (ready),
    .pause_done(pause_done),
    .tick      (tick)
  );

  rfsh_owed #(
    .MAX_OWED(MAX_OWED)
  ) u_owed (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .inc  (tick),
    .dec  (start_run),
    .empty(empty),
    .full (full)
  );

  rfsh_cycle #(
    .T_RPC(T_RPC),
    .T_CSR(T_CSR),
    .T_RAS(T_RAS),
    .T_CHR(T_CHR),
    .T_RP (T_RP)
  ) u_cycle (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .start(start_any),
    .busy (busy),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );

  // start decisions
  always_comb begin
    ready      = (phase == PH_RUN);
    req        = ready && !empty && !busy;
    start_run  = req && grant;
    start_wake = (phase == PH_WAKE) && !busy && (wake_left != '0);
    start_any  = start_run || start_wake;
    urgent     = ready && full;
    strobe_own = busy || !ready;
  end

  // phase sequencing
  always_comb begin
    phase_n     = phase;
    wake_en     = start_wake;
    wake_left_n = wake_left - WW'(1);
    case (phase)
      PH_PAUSE: if (pause_done) phase_n = PH_WAKE;
      PH_WAKE:  if ((wake_left == '0) && !busy) phase_n = PH_RUN;
      default:  phase_n = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase     <= PH_PAUSE;
      wake_left <= WW'(WAKE_CYC);
    end else begin
      phase <= phase_n;
      if (wake_en) wake_left <= wake_left_n;
    end
  end

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_PAUSE) |-> (ras_n && cas_n && !ready));

  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |=> ready);

  assert_start_granted_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(busy) && ready) |-> $past(grant));

  assert_urgent_owes_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    urgent |-> (req || busy));

endmodule

// File: tb/tb_rfsh_sched.sv
module tb_rfsh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE   = 50;
  localparam int WAKE    = 8;
  localparam int IVL     = 40;
  localparam int MAXO    = 8;
  localparam int T_RPC   = 1;
  localparam int T_CSR   = 1;
  localparam int T_RAS   = 7;
  localparam int T_CHR   = 2;
  localparam int T_RP    = 5;
  localparam int WD_LIMIT = 20000;

  logic clk, rst_n, grant;
  logic req, urgent, ready, strobe_own, ras_n, cas_n;

  int checks, fails, cyc;
  int n, m_owed, ras_falls;
  bit ready_seen, prev_ras, prev_cas, prev_own;
  int ras_low_run, ras_high_run, cas_low_run;

  rfsh_sched #(
    .PAUSE_CYC(PAUSE), .WAKE_CYC(WAKE), .INTERVAL_CYC(IVL), .MAX_OWED(MAXO),
    .T_RPC(T_RPC), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_CHR(T_CHR), .T_RP(T_RP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .urgent(urgent),
    .ready(ready), .strobe_own(strobe_own), .ras_n(ras_n), .cas_n(cas_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  // strobe timing monitor and owed-count model
  always @(negedge clk) begin
    if (!rst_n) begin
      n = 0; m_owed = 0; ras_falls = 0; ready_seen = 0;
      prev_ras = 1; prev_cas = 1; prev_own = 1;
      ras_low_run = 0; ras_high_run = 0; cas_low_run = 0;
    end else begin
      if (!prev_ras && ras_n)
        chk(ras_low_run == T_RAS, "R5 ras low width", ras_low_run, T_RAS);
      if (prev_ras && !ras_n) begin
        ras_falls++;
        chk(!cas_n && cas_low_run == T_CSR, "R4 cas lead before ras fall", cas_low_run, T_CSR);
        chk(ras_high_run >= T_RP + T_RPC + T_CSR, "R6 ras high gap", ras_high_run, T_RP + T_RPC + T_CSR);
      end
      if (prev_cas && !cas_n)
        chk(ras_n && ras_high_run >= T_RPC, "R4 ras high before cas fall", ras_high_run, T_RPC);
      if (!prev_cas && cas_n)
        chk(cas_low_run == T_CSR + T_CHR, "R5 cas low width", cas_low_run, T_CSR + T_CHR);
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      cas_low_run  = cas_n ? 0 : cas_low_run + 1;
      prev_ras = ras_n;
      prev_cas = cas_n;
      if (ready) begin
        if (!ready_seen) begin
          ready_seen = 1; n = 0; m_owed = 0;
        end else begin
          bit tk, st;
          n++;
          tk = (n % IVL == 0);
          st = !prev_own && strobe_own;
          if (tk && !st && m_owed < MAXO) m_owed++;
          else if (st && !tk && m_owed > 0) m_owed--;
        end
        chk(req == (m_owed != 0 && !strobe_own), "R7 req vs owed model", int'(req), int'(m_owed != 0 && !strobe_own));
        chk(urgent == (m_owed == MAXO), "R9 urgent vs owed model", int'(urgent), int'(m_owed == MAXO));
      end else begin
        chk(strobe_own, "R11 strobes owned before ready", int'(strobe_own), 1);
        chk(!req && !urgent, "R8 no request before ready", int'(req), 0);
      end
      prev_own = strobe_own;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; grant = 1'b0;
    repeat (3) step();
    chk(!ready && !req && !urgent, "R1 reset flags", int'(ready) + int'(req) + int'(urgent), 0);
    chk(ras_n && cas_n, "R1 reset strobes high", int'(ras_n) + int'(cas_n), 2);
    chk(strobe_own, "R1 reset ownership", int'(strobe_own), 1);
  endtask

  task automatic t_pause();
    int bad = 0;
    rst_n = 1'b1;
    for (int i = 0; i < PAUSE; i++) begin
      step();
      if (!ras_n || !cas_n || ready) bad++;
    end
    chk(bad == 0, "R2 quiet during pause", bad, 0);
  endtask

  task automatic t_wake();
    for (int i = 0; i < 2000 && !ready; i++) step();
    chk(ready, "R3 ready reached", int'(ready), 1);
    chk(ras_falls == WAKE, "R3 wake-up cycle count", ras_falls, WAKE);
  endtask

  task automatic t_interval();
    for (int i = 0; i < 4 * IVL && !req; i++) step();
    chk(req && n == IVL, "R7 first request delay", n, IVL);
    chk(ras_falls == WAKE, "R8 no cycle without grant", ras_falls, WAKE);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 12 * IVL && !urgent; i++) step();
    chk(urgent && n == MAXO * IVL, "R9 urgent onset", n, MAXO * IVL);
    repeat (2 * IVL + 3) step();
    chk(urgent, "R9 saturated count stays full", int'(urgent), 1);
    chk(ras_falls == WAKE, "R8 strobes idle while ungranted", ras_falls, WAKE);
  endtask

  task automatic t_coincide();
    for (int i = 0; i < 2 * IVL && ((n + 1) % IVL != 0); i++) step();
    grant = 1'b1;
    step();
    grant = 1'b0;
    chk(strobe_own, "R10 start on tick edge", int'(strobe_own), 1);
    chk(urgent, "R10 full count kept on coincidence", int'(urgent), 1);
  endtask

  task automatic t_catchup();
    int f0, f1;
    f0 = ras_falls;
    grant = 1'b1;
    step();
    for (int i = 0; i < 3000 && (req || strobe_own); i++) step();
    chk(!req && !strobe_own, "R7 owed drained", int'(req), 0);
    chk(ras_falls - f0 >= MAXO, "R7 catch-up refresh count", ras_falls - f0, MAXO);
    grant = 1'b0;
    step();
    f1 = ras_falls;
    repeat (3 * IVL) step();
    chk(ras_falls == f1, "R8 no refresh after grant drops", ras_falls - f1, 0);
    chk(req, "R8 request pending without grant", int'(req), 1);
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0;
    t_reset();
    t_pause();
    t_wake();
    t_interval();
    t_saturate();
    t_coincide();
    t_catchup();
    summary();
  end

endmodule